// File: doc/BRIEF.md
# Processor Interrupt Dispatch Unit

This block stands between the interrupt sources of a system and a processor core. It records three kinds of request as pending state: a core reset request, a non-maskable request and a vector of maskable level bits. It then decides, at the points where the core finishes an instruction, whether an exception must be taken. The core marks each such point with a one-cycle strobe and supplies its global interrupt enable bit and its per-level mask.

At each such point the unit issues at most one exception request, chosen by fixed priority. A core reset request wins over a non-maskable request, and both win over the maskable levels. The two high-priority kinds share one exception code. A maskable request that the core currently blocks is not lost: it stays pending and is tried again at every later instruction boundary. The unit does not vector the exception and does not touch the core's cause or status registers.

Top module: `irq_dispatch`

## Requirements
- R1: A synchronous active-high `rst` clears every pending flag and the level register, and drives `exc_valid_o` to 0 and `exc_type_o` to 2'b00; after reset, a boundary with interrupts enabled and every mask bit set raises nothing.
- R2: Each cycle, the bits of `lvl_req_i` are ORed into the pending level register, so bits from separate cycles accumulate until a maskable delivery clears them.
- R3: At one boundary at most one exception is issued, with strict priority: pending core reset request first, then pending non-maskable request, then pending maskable levels.
- R4: Core reset and non-maskable deliveries both use `exc_type_o` = 2'b01, and each clears only its own pending flag, so the other stays pending.
- R5: A maskable exception (`exc_type_o` = 2'b10) is issued only when `ie_i` is 1 and the pending level bits ANDed with `mask_i` (bit i of the mask enables level bit i) are nonzero.
- R6: A maskable delivery clears the whole pending level register, masked bits included.
- R7: Level bits blocked by `ie_i` or by `mask_i` stay pending and are judged again at every later boundary.
- R8: Decisions are made only in cycles with `instr_boundary_i` = 1; the result shows on `exc_valid_o`/`exc_type_o` in the cycle after that boundary cycle and lasts one cycle per delivery.
- R9: A request arriving in the same cycle that its pending state is cleared by delivery is kept as pending (new level bits, or a fresh core reset or non-maskable request).
- R10: Whenever `exc_valid_o` is 0, `exc_type_o` is 2'b00.
- R11: A request that arrives in a boundary cycle is not judged at that boundary but at the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| core_rst_req_i | input | 1 | Core reset request, one-cycle pulse |
| nmi_req_i | input | 1 | Non-maskable request, one-cycle pulse |
| lvl_req_i | input | LVL_W (6) | Maskable level bits arriving this cycle |
| instr_boundary_i | input | 1 | Core has just completed an instruction |
| ie_i | input | 1 | Core global interrupt enable |
| mask_i | input | LVL_W (6) | Core per-level interrupt mask, 1 = enabled |
| exc_valid_o | output | 1 | Exception request, one cycle per delivery |
| exc_type_o | output | 2 | 01 = core reset/non-maskable, 10 = maskable, 00 = none |

## Verification
On every cycle the assertions check that level bits only ever leave the pending register through a maskable delivery, that such a delivery leaves exactly the bits that arrived alongside it, that a new request always survives its own service, that an exception never appears without a preceding boundary, that a maskable exception was both enabled and unmasked, and that the code is zero when idle. The bench scenarios show what spans several boundaries: the full three-way priority drain, the masked request that waits through blocked boundaries and is then taken, the reset flag clearing while the non-maskable flag stays, and a same-cycle request being held for the following boundary.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    parameter int unsigned IRQ_LVL_W = 6;

    typedef enum logic [1:0] {
        EXC_NONE = 2'b00,
        EXC_NMI  = 2'b01,
        EXC_INT  = 2'b10
    } exc_kind_e;

    typedef struct packed {
        logic      take_rst;
        logic      take_nmi;
        logic      take_int;
        exc_kind_e kind;
    } exc_decision_t;

    // Fixed-priority choice made at an instruction boundary.
    function automatic exc_decision_t arbitrate(
        input logic at_bnd,
        input logic rst_p,
        input logic nmi_p,
        input logic ie,
        input logic lvl_hit
    );
        exc_decision_t d;
        d.take_rst = 1'b0;
        d.take_nmi = 1'b0;
        d.take_int = 1'b0;
        d.kind     = EXC_NONE;
        if (at_bnd) begin
            if (rst_p) begin
                d.take_rst = 1'b1;
                d.kind     = EXC_NMI;
            end else if (nmi_p) begin
                d.take_nmi = 1'b1;
                d.kind     = EXC_NMI;
            end else if (ie && lvl_hit) begin
                d.take_int = 1'b1;
                d.kind     = EXC_INT;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // A fresh request wins over the clear of the one being serviced.
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_set_kept_r9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    p_hold_until_served_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/irq_level_accum.sv
module irq_level_accum #(
    parameter int unsigned LVL_W = irq_dispatch_pkg::IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] lvl_in_i,
    input  logic             take_i,
    output logic [LVL_W-1:0] pend_o
);
    logic [LVL_W-1:0] pend_q;
    logic [LVL_W-1:0] pend_d;

    always_comb begin
        if (take_i) pend_d = lvl_in_i;          // group clear, arrivals kept
        else        pend_d = pend_q | lvl_in_i; // accumulate
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    p_no_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> (($past(pend_q) & ~pend_q) == '0));

    p_accum_r2: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> ((pend_q & $past(lvl_in_i)) == $past(lvl_in_i)));

    p_group_clear_r6: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (pend_q == $past(lvl_in_i)));

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_dispatch_pkg::*;
#(
    parameter int unsigned LVL_W = IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bnd_i,
    input  logic             rst_pend_i,
    input  logic             nmi_pend_i,
    input  logic [LVL_W-1:0] lvl_pend_i,
    input  logic             ie_i,
    input  logic [LVL_W-1:0] mask_i,
    output logic             take_rst_o,
    output logic             take_nmi_o,
    output logic             take_int_o,
    output logic             exc_valid_o,
    output exc_kind_e        exc_kind_o
);
    logic          lvl_hit;
    exc_decision_t dec;
    logic          valid_q;
    exc_kind_e     kind_q;

    assign lvl_hit = |(lvl_pend_i & mask_i);

    always_comb dec = arbitrate(bnd_i, rst_pend_i, nmi_pend_i, ie_i, lvl_hit);

    assign take_rst_o = dec.take_rst;
    assign take_nmi_o = dec.take_nmi;
    assign take_int_o = dec.take_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            kind_q  <= EXC_NONE;
        end else begin
            valid_q <= dec.take_rst | dec.take_nmi | dec.take_int;
            kind_q  <= dec.kind;
        end
    end

    assign exc_valid_o = valid_q;
    assign exc_kind_o  = kind_q;

    p_only_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(bnd_i));

    p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (kind_q == EXC_NONE));

    p_reset_first_r3: assert property (@(posedge clk) disable iff (rst)
        (bnd_i && rst_pend_i) |=> (valid_q && kind_q == EXC_NMI));

    p_int_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && kind_q == EXC_INT) |-> ($past(ie_i) && ($past(lvl_pend_i & mask_i) != '0)));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int unsigned LVL_W = IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_rst_req_i,
    input  logic             nmi_req_i,
    input  logic [LVL_W-1:0] lvl_req_i,
    input  logic             instr_boundary_i,
    input  logic             ie_i,
    input  logic [LVL_W-1:0] mask_i,
    output logic             exc_valid_o,
    output logic [1:0]       exc_type_o
);
    logic             rst_pend;
    logic             nmi_pend;
    logic [LVL_W-1:0] lvl_pend;
    logic             take_rst;
    logic             take_nmi;
    logic             take_int;
    exc_kind_e        kind;

    irq_sticky_flag u_rst_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (core_rst_req_i),
        .clr_i  (take_rst),
        .flag_o (rst_pend)
    );

    irq_sticky_flag u_nmi_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (nmi_req_i),
        .clr_i  (take_nmi),
        .flag_o (nmi_pend)
    );

    irq_level_accum #(.LVL_W(LVL_W)) u_lvl (
        .clk      (clk),
        .rst      (rst),
        .lvl_in_i (lvl_req_i),
        .take_i   (take_int),
        .pend_o   (lvl_pend)
    );

    irq_select #(.LVL_W(LVL_W)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .bnd_i       (instr_boundary_i),
        .rst_pend_i  (rst_pend),
        .nmi_pend_i  (nmi_pend),
        .lvl_pend_i  (lvl_pend),
        .ie_i        (ie_i),
        .mask_i      (mask_i),
        .take_rst_o  (take_rst),
        .take_nmi_o  (take_nmi),
        .take_int_o  (take_int),
        .exc_valid_o (exc_valid_o),
        .exc_kind_o  (kind)
    );

    assign exc_type_o = kind;

    p_one_take_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_rst, take_nmi, take_int}));

endmodule

// File: tb/irq_dispatch_bench.sv
`timescale 1ns/1ps
module irq_dispatch_bench;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         core_rst_req_i = 1'b0;
    logic         nmi_req_i = 1'b0;
    logic [W-1:0] lvl_req_i = '0;
    logic         instr_boundary_i = 1'b0;
    logic         ie_i = 1'b0;
    logic [W-1:0] mask_i = '0;
    logic         exc_valid_o;
    logic [1:0]   exc_type_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_dispatch #(.LVL_W(W)) u_irq_dispatch (
        .clk(clk), .rst(rst), .core_rst_req_i(core_rst_req_i),
        .nmi_req_i(nmi_req_i), .lvl_req_i(lvl_req_i),
        .instr_boundary_i(instr_boundary_i), .ie_i(ie_i), .mask_i(mask_i),
        .exc_valid_o(exc_valid_o), .exc_type_o(exc_type_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic v, input logic [1:0] t, input string tag);
        total++;
        if (exc_valid_o !== v || exc_type_o !== t) begin
            bad++;
            $display("FAIL %s: valid=%0b type=%02b expected valid=%0b type=%02b",
                     tag, exc_valid_o, exc_type_o, v, t);
        end
    endtask

    // Boundary for one cycle, then check the registered result.
    task automatic boundary(input logic v, input logic [1:0] t, input string tag);
        instr_boundary_i = 1'b1;
        tick();
        instr_boundary_i = 1'b0;
        expect_out(v, t, tag);
    endtask

    task automatic pulse_lvl(input logic [W-1:0] b);
        lvl_req_i = b;
        tick();
        lvl_req_i = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic t_reset_r1();
        nmi_req_i = 1'b1; lvl_req_i = 6'h3F;
        rst = 1'b1; tick(); tick();
        nmi_req_i = 1'b0; lvl_req_i = '0;
        expect_out(1'b0, 2'b00, "R1 outputs in reset");
        rst = 1'b0;
        ie_i = 1'b1; mask_i = 6'h3F;
        boundary(1'b0, 2'b00, "R1 nothing pending after reset");
    endtask

    task automatic t_accum_r2_r6();
        do_reset();
        pulse_lvl(6'h01);
        pulse_lvl(6'h04);
        ie_i = 1'b0; mask_i = 6'h3F;
        boundary(1'b0, 2'b00, "R5 ie low blocks");
        ie_i = 1'b1; mask_i = 6'h01;
        boundary(1'b1, 2'b10, "R2 first bit kept after second arrival");
        mask_i = 6'h04;
        boundary(1'b0, 2'b00, "R6 masked bit cleared with group");
    endtask

    task automatic t_priority_r3_r4();
        do_reset();
        core_rst_req_i = 1'b1; nmi_req_i = 1'b1; lvl_req_i = 6'h08;
        tick();
        core_rst_req_i = 1'b0; nmi_req_i = 1'b0; lvl_req_i = '0;
        ie_i = 1'b1; mask_i = 6'h3F;
        boundary(1'b1, 2'b01, "R3 core reset first");
        boundary(1'b1, 2'b01, "R4 nmi still pending after reset served");
        boundary(1'b1, 2'b10, "R3 level last");
        boundary(1'b0, 2'b00, "R3 all drained");
        nmi_req_i = 1'b1; tick(); nmi_req_i = 1'b0;
        boundary(1'b1, 2'b01, "R4 nmi alone uses code 01");
    endtask

    task automatic t_masked_retry_r5_r7();
        do_reset();
        pulse_lvl(6'h20);
        ie_i = 1'b0; mask_i = 6'h3F;
        boundary(1'b0, 2'b00, "R5 disabled");
        ie_i = 1'b1; mask_i = 6'h1F;
        boundary(1'b0, 2'b00, "R5 bit masked");
        boundary(1'b0, 2'b00, "R7 still masked later");
        mask_i = 6'h3F;
        boundary(1'b1, 2'b10, "R7 retried and taken");
    endtask

    task automatic t_boundary_only_r8();
        do_reset();
        pulse_lvl(6'h02);
        ie_i = 1'b1; mask_i = 6'h3F;
        tick(); tick();
        expect_out(1'b0, 2'b00, "R8 no boundary no exception");
        boundary(1'b1, 2'b10, "R8 boundary delivers");
        tick();
        expect_out(1'b0, 2'b00, "R8 single-cycle pulse");
    endtask

    task automatic t_same_cycle_r9();
        do_reset();
        pulse_lvl(6'h01);
        ie_i = 1'b1; mask_i = 6'h3F;
        lvl_req_i = 6'h02;
        boundary(1'b1, 2'b10, "R9 delivery with new arrival");
        lvl_req_i = '0;
        mask_i = 6'h02;
        boundary(1'b1, 2'b10, "R9 arrival in clear cycle kept");
        core_rst_req_i = 1'b1; tick();
        boundary(1'b1, 2'b01, "R9 reset served while new reset arrives");
        core_rst_req_i = 1'b0;
        boundary(1'b1, 2'b01, "R9 fresh reset request kept");
        boundary(1'b0, 2'b00, "R9 drained");
    endtask

    task automatic t_late_arrival_r11();
        do_reset();
        ie_i = 1'b1; mask_i = 6'h3F;
        nmi_req_i = 1'b1;
        boundary(1'b0, 2'b00, "R11 same-cycle nmi not judged");
        nmi_req_i = 1'b0;
        boundary(1'b1, 2'b01, "R11 nmi judged at next boundary");
        lvl_req_i = 6'h10;
        boundary(1'b0, 2'b00, "R11 same-cycle level not judged, R10 code 00");
        lvl_req_i = '0;
        boundary(1'b1, 2'b10, "R11 level judged at next boundary");
    endtask

    initial begin
        tick();
        t_reset_r1();
        t_accum_r2_r6();
        t_priority_r3_r4();
        t_masked_retry_r5_r7();
        t_boundary_only_r8();
        t_same_cycle_r9();
        t_late_arrival_r11();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule